// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides, cycle by cycle, whether a new task may be started in a pipeline that has a fixed schedule. That schedule sets which stages a task uses in which cycles. The forbidden start distances of the schedule are packed into a parameter bit vector, the initial collision vector. The controller keeps a state register called the collision vector. A 1 in this register marks a start distance that would make two tasks claim the same stage in the same cycle. A 0 marks a free distance.

Every clock the state moves one position toward the most significant end. Its top bit is dropped and a 0 enters at the bottom. When a request is present and the bit that rules the next distance is clear, the block grants at once. In that case it ORs the initial vector into the moved state, so the new task's own forbidden distances are added to those still pending. A request that cannot be granted is not stored. The requester holds it until a grant comes.

The block starts a task at the first free slot it sees. Under a constant stream of requests it therefore falls into the shortest greedy latency cycle that the vector allows. A small latency counter shows how many cycles lie between the last two grants, so the cadence can be observed from outside.

Top module: `coll_vec_init_ctrl`

## Requirements
- R1: During synchronous active-low reset and on the first clock after it, the state is all zeros and the latency output is W+1 (7 for W=6). A request in the first cycle after reset is granted.
- R2: `grant_o` is combinational. It equals `req_i` AND NOT `cv_o[W-2]`. Bit W-1-L of the state marks start distance L, so the MSB stands for distance 0 and bit W-2 for distance 1.
- R3: In a cycle without a grant, the next state is the current state shifted left by one. The MSB is discarded and bit 0 becomes 0.
- R4: In a cycle with a grant, the next state is the left-shifted state bitwise-ORed with the parameter ICV.
- R5: A request that is denied leaves no trace. The state only shifts, the latency counter keeps counting, and the request is granted later only if it is still asserted.
- R6: An all-zero state with no request stays all zeros. From that state a request is granted whatever the wait before it.
- R7: After a grant, `lat_o` reads 1. Each cycle without a grant adds 1 up to a ceiling of W+1, where it stays. In a grant cycle `lat_o` therefore gives the distance since the previous grant.
- R8: With ICV = 101001 and the request held high, the grants follow the latency pattern 1,3,3 with period 7. The state runs through 101001, 111011, 110110, 101100, 111001, 110010, 100100 and back to 101001.
- R9: After an idle gap longer than W, a request is granted in the cycle it arrives, and the state becomes exactly ICV on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | A task is waiting to start |
| grant_o | output | 1 | Task starts this cycle |
| cv_o | output | W | Current collision vector state |
| lat_o | output | $clog2(W+2) | Cycles since last grant, saturating at W+1 |

## Verification
The bench builds the block with its default parameters, W = 6 and ICV = 101001. With these values the full greedy 1,3,3 loop and its seven states can be reached, and so can the latency ceiling of 7 after idle gaps. Runs of denied requests are also exercised against the three forbidden distances that sit inside the loop. The six-bit width keeps the whole state sequence short enough to list as exact expected values, and a bench model covers the irregular request patterns.

// File: rtl/cvic_pkg.sv
// Package: shared helpers for the collision-vector initiation controller.
// Assumes the vector width is at least 2.
package cvic_pkg;

    // Width of a counter that must hold values up to w+1.
    function automatic int lat_width(input int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/cvic_shift.sv
// Module: cvic_shift
// Moves the collision vector one place toward the MSB and fills bit 0 with
// zero. It also reports whether the slot one cycle ahead is free, which is
// the MSB of the moved vector. Purely combinational.
// Assumes W >= 2.
module cvic_shift #(
    parameter int W = 6
) (
    input  logic [W-1:0] cv_i,
    output logic [W-1:0] moved_o,
    output logic         free_o
);

    // One stage of the move per bit; the bottom bit always takes a zero.
    assign moved_o[0] = 1'b0;
    for (genvar b = 1; b < W; b++) begin : g_mv
        assign moved_o[b] = cv_i[b-1];
    end

    // The slot is free when no pending forbidden distance covers it.
    assign free_o = ~moved_o[W-1];

endmodule

// File: rtl/cvic_state.sv
// Module: cvic_state
// Holds the collision vector. On a load the moved vector is merged with the
// initial vector; otherwise the moved vector is stored as it is.
// Assumes a synchronous active-low reset that clears the vector (empty pipe).
module cvic_state #(
    parameter int         W   = 6,
    parameter logic [W-1:0] ICV = 6'b101001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] moved_i,
    output logic [W-1:0] cv_o
);

    logic [W-1:0] cv_q;
    logic [W-1:0] cv_d;

    // Choose the merged or the plain moved vector as next state.
    always_comb begin
        cv_d = load_i ? (moved_i | ICV) : moved_i;
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cv_q <= '0;
        else        cv_q <= cv_d;
    end

    assign cv_o = cv_q;

    AST_MERGE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((cv_q & ICV) == ICV)); // R4

    AST_SHIFT_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cv_q == {$past(cv_q[W-2:0]), 1'b0})); // R3

endmodule

// File: rtl/cvic_latency.sv
// Module: cvic_latency
// Counts cycles since the last grant. It restarts at 1 after a grant and
// saturates at W+1. The reset value is the ceiling, meaning no recent grant.
// Assumes LW is wide enough to hold W+1.
module cvic_latency #(
    parameter int W  = 6,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_i,
    output logic [LW-1:0] lat_o
);

    localparam logic [LW-1:0] LAT_MAX = LW'(W + 1);
    localparam logic [LW-1:0] LAT_ONE = LW'(1);

    logic [LW-1:0] lat_q;

    // Restart on grant, otherwise count up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)               lat_q <= LAT_MAX;
        else if (grant_i)         lat_q <= LAT_ONE;
        else if (lat_q < LAT_MAX) lat_q <= lat_q + LAT_ONE;
    end

    assign lat_o = lat_q;

    AST_LAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> (lat_q == LAT_ONE)); // R7

    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q >= LAT_ONE) && (lat_q <= LAT_MAX)); // R7

    AST_LAT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_MAX) && !grant_i |=> (lat_q == LAT_MAX)); // R7

endmodule

// File: rtl/coll_vec_init_ctrl.sv
// Module: coll_vec_init_ctrl (top)
// Greedy start controller for a statically scheduled pipeline. It grants a
// waiting request whenever the collision vector leaves the next slot free
// and merges the initial vector into the state on every grant.
// Assumes W >= 2. ICV is the forbidden-distance set of one task, and its MSB
// stands for distance 0. A denied request is held by the requester.
module coll_vec_init_ctrl
    import cvic_pkg::*;
#(
    parameter int           W   = 6,
    parameter logic [W-1:0] ICV = 6'b101001,
    localparam int          LW  = lat_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output logic          grant_o,
    output logic [W-1:0]  cv_o,
    output logic [LW-1:0] lat_o
);

    logic [W-1:0] cv_w;
    logic [W-1:0] moved_w;
    logic         free_w;

    // Move the present state and look at the slot it exposes.
    cvic_shift #(.W(W)) u_shift (
        .cv_i    (cv_w),
        .moved_o (moved_w),
        .free_o  (free_w)
    );

    // Grant as soon as a request meets a free slot.
    always_comb begin
        grant_o = req_i & free_w;
    end

    // Keep the collision vector.
    cvic_state #(.W(W), .ICV(ICV)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (grant_o),
        .moved_i (moved_w),
        .cv_o    (cv_w)
    );

    // Track the spacing between grants.
    cvic_latency #(.W(W), .LW(LW)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant_o),
        .lat_o   (lat_o)
    );

    assign cv_o = cv_w;

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_o == '0) && !req_i |=> (cv_o == '0)); // R6

    AST_EMPTY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_o == '0) && req_i |-> grant_o); // R9

    AST_DENIED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !grant_o |=> (lat_o != LW'(1))); // R5

endmodule

// File: tb/sim_coll_vec_init_ctrl.sv
// Scoreboard bench: the driver pushes the expected cycle results and the
// monitor pops them and compares them with the outputs.
module sim_coll_vec_init_ctrl;

    localparam int          W   = 6;
    localparam logic [W-1:0] ICV = 6'b101001;
    localparam int          LW  = $clog2(W + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          grant;
    logic [W-1:0]  cv;
    logic [LW-1:0] lat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected item layout: {grant, cv, lat}.
    logic [W+LW:0] exp_q[$];
    string         tag_q[$];

    // Bench model state, taken from the requirements.
    logic [W-1:0]  m_cv;
    logic [LW-1:0] m_lat;

    always #4 clk = ~clk;  // 125 MHz

    coll_vec_init_ctrl #(.W(W), .ICV(ICV)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant),
        .cv_o    (cv),
        .lat_o   (lat)
    );

    task automatic push(input logic g, input logic [W-1:0] c,
                        input logic [LW-1:0] l, input string t);
        exp_q.push_back({g, c, l});
        tag_q.push_back(t);
    endtask

    // Drive one cycle with exact expected values.
    task automatic step_lit(input logic r, input logic g,
                            input logic [W-1:0] c, input int l, input string t);
        @(negedge clk);
        req = r;
        push(g, c, LW'(l), t);
    endtask

    // Drive one cycle with expectations from the model (R2, R3, R4, R7).
    task automatic step(input logic r, input string t);
        logic g;
        logic [W-1:0] sh;
        @(negedge clk);
        req = r;
        g = r && !m_cv[W-2];
        push(g, m_cv, m_lat, t);
        sh = {m_cv[W-2:0], 1'b0};
        m_cv = g ? (sh | ICV) : sh;
        if (g) m_lat = LW'(1);
        else if (m_lat < LW'(W + 1)) m_lat = m_lat + LW'(1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cv = '0;
        m_lat = LW'(W + 1);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [W+LW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({grant, cv, lat} !== e) begin
                    errors++;
                    $display("FAIL %s: got grant=%b cv=%b lat=%0d, expected grant=%b cv=%b lat=%0d",
                             t, grant, cv, lat, e[W+LW], e[W+LW-1:LW], e[LW-1:0]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: first cycle after reset, request granted from the empty state.
        step_lit(1'b1, 1'b1, 6'b000000, 7, "R1 reset state and first grant");
        // R8: greedy loop with the request held, three full periods.
        for (int k = 0; k < 3; k++) begin
            step_lit(1'b1, 1'b1, 6'b101001, 1, "R8 greedy 101001");
            step_lit(1'b1, 1'b0, 6'b111011, 1, "R8 greedy 111011");
            step_lit(1'b1, 1'b0, 6'b110110, 2, "R8 greedy 110110");
            step_lit(1'b1, 1'b1, 6'b101100, 3, "R8 greedy 101100");
            step_lit(1'b1, 1'b0, 6'b111001, 1, "R8 greedy 111001");
            step_lit(1'b1, 1'b0, 6'b110010, 2, "R8 greedy 110010");
            step_lit(1'b1, 1'b1, 6'b100100, 3, "R8 greedy 100100");
        end
        m_cv = ICV;
        m_lat = LW'(1);
        // R3, R6, R7: idle drains the vector and saturates the counter.
        for (int k = 0; k < 10; k++) step(1'b0, "R3 R6 R7 idle drain");
        // R9: a grant after a long gap reloads exactly ICV.
        step(1'b1, "R9 grant after idle");
        step_lit(1'b0, 1'b0, ICV, 1, "R9 state equals ICV");
        m_cv = {ICV[W-2:0], 1'b0};
        m_lat = LW'(2);
        // R5: a request held through denied slots, then dropped.
        step(1'b0, "R5 pre");
        step(1'b1, "R5 held request");
        step(1'b1, "R5 held request");
        step(1'b1, "R5 held request");
        step(1'b0, "R5 after release");
        step(1'b1, "R2 single request");
        step(1'b0, "R2 gap");
        step(1'b1, "R2 single request");
        step(1'b1, "R2 back to back");
        for (int k = 0; k < 3; k++) step(1'b0, "R7 count");
        for (int k = 0; k < 6; k++) step(k[0], "R2 alternating");
        for (int k = 0; k < 8; k++) step(1'b0, "R6 idle again");
        // R1: a reset in the middle of activity returns to the empty state.
        step(1'b1, "R1 before reset");
        do_reset();
        step(1'b0, "R1 after mid reset");
        step(1'b1, "R1 grant after mid reset");
        step(1'b1, "R2 after mid reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule